// File: doc/BRIEF.md
# Embedded-Clock Word Deserializer with Frame Lock

This block takes a serial bit stream, one bit per clock, in which every word occupies twelve bit periods: a start clock bit of value 1, ten payload bits sent least significant first, and a stop clock bit of value 0. The bit clock is assumed to be recovered and phase-aligned already. The block hunts for the word boundary by checking the start/stop pair. It declares lock after a run of well-framed words and then hands out ten-bit words with a one-cycle valid pulse and a recovered word strobe.

The output side is a valid-only stream. The line cannot be paused, so there is no ready input and no back-pressure. A sink must accept every word in the cycle that `word_vld` is high. Valid pulses come exactly twelve cycles apart while lock holds. The data and strobe outputs carry meaning only while `out_en` is high, and they are driven to zero otherwise. This models the high-impedance state. `lock_n` is the active-low lock flag. `pwrdn_n` is the active-low powerdown, and it also serves as the block's only reset.

The strobe select picks which edge of `word_strb` qualifies the data. In both cases that edge falls in the middle of the word period, six cycles after the word appears. A training word has payload 0x01F: five ones in the low bits, then five zeros. A repeated training word has only one alignment that frames correctly, so it bounds the lock time.

Top module: `emb_clk_deser`

## Requirements
- R1: Bit i of `word_q` is the i-th payload bit received after the start bit; the start bit is 1 and the stop bit (twelfth bit) is 0; a word is presented on `word_q` with `word_vld` high in the cycle after its stop bit is sampled.
- R2: Starting from the hunt, after 8 consecutive correctly framed words at one alignment (any payload), `lock_n` goes low and `out_en` goes high in the cycle after the eighth stop bit, and that eighth word is the first one presented.
- R3: While `out_en` is low, `word_vld`, `word_q` and `word_strb` are all 0.
- R4: During the hunt, every badly framed word moves the next frame window one bit later. From a stream of three 0 bits followed by repeated training words, lock is declared after exactly eleven training words.
- R5: While locked, a run of fewer than 4 consecutive badly framed words keeps lock, and those words are still presented. A well-framed word ends the run.
- R6: The fourth consecutive badly framed word while locked raises `lock_n` and lowers `out_en` in the following cycle, and that word is not presented.
- R7: A training word (payload 0x01F) counts as well framed and is presented as 0x01F.
- R8: With `strb_fall`=0, `word_strb` is 0 for the six cycles starting at the valid cycle and 1 for the next six, so it rises six cycles after `word_vld`. With `strb_fall`=1 the waveform is inverted.
- R9: While `pwrdn_n` is low, `lock_n` is 1 and `out_en` is 0 without waiting for a clock. All framing and lock state is cleared, so after release eight new good words are needed for lock.
- R10: `word_vld` is high for one cycle per presented word, and presented words are twelve cycles apart while lock holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| pwrdn_n | input | 1 | Active-low powerdown; asynchronously clears all state |
| ser_in | input | 1 | Serial data bit, sampled on the rising clock edge |
| strb_fall | input | 1 | Strobe edge select: 0 rising edge qualifies data, 1 falling |
| word_q | output | 10 | Parallel payload word, 0 while disabled |
| word_vld | output | 1 | One-cycle valid pulse per presented word |
| word_strb | output | 1 | Recovered word strobe, 0 while disabled |
| lock_n | output | 1 | Active-low lock flag |
| out_en | output | 1 | Output enable for data and strobe (high when locked) |

## Verification
A word, its valid pulse and any change of lock state all appear one cycle after the stop bit is sampled. The bench drives each bit at a falling edge, so it checks those results at the falling edge that follows the last bit of a frame. The strobe is due six cycles after the valid pulse and toggles back twelve cycles after it. The bench counts bit periods from the valid cycle and samples after the fifth and sixth bits. Powerdown acts without a clock and is checked one time unit after `pwrdn_n` falls.

// File: rtl/emb_deser_pkg.sv
package emb_deser_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;
endpackage

// File: rtl/emb_deser_framer.sv
module emb_deser_framer #(
  parameter int PAY_W = 10
) (
  input  logic             clk,
  input  logic             pwrdn_n,
  input  logic             ser_in,
  input  logic             slip_req,
  output logic             frame_end,
  output logic             frame_ok,
  output logic [PAY_W-1:0] payload
);
  localparam int FW = PAY_W + 2;
  localparam int CW = $clog2(FW);

  logic [FW-1:0] sr_q, sr_nxt;
  logic [CW-1:0] cnt_q;
  logic          slip_pend_q;

  // newest bit enters at the top; the oldest (start) ends at bit 0
  assign sr_nxt    = {ser_in, sr_q[FW-1:1]};
  assign frame_end = (cnt_q == CW'(FW-1));
  assign frame_ok  = sr_nxt[0] & ~sr_nxt[FW-1];
  assign payload   = sr_nxt[FW-2:1];

  always_ff @(posedge clk or negedge pwrdn_n) begin
    if (!pwrdn_n) begin
      sr_q        <= '0;
      cnt_q       <= '0;
      slip_pend_q <= 1'b0;
    end else begin
      sr_q <= sr_nxt;
      if (slip_pend_q) begin
        // hold the count one bit: the window moves one bit later
        slip_pend_q <= 1'b0;
      end else if (frame_end) begin
        cnt_q       <= '0;
        slip_pend_q <= slip_req;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/emb_deser_lock.sv
module emb_deser_lock
  import emb_deser_pkg::*;
#(
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic clk,
  input  logic pwrdn_n,
  input  logic frame_end,
  input  logic frame_ok,
  output logic locked,
  output logic locked_nxt,
  output logic slip_req
);
  localparam int GW = $clog2(LOCK_FRAMES + 1);
  localparam int BW = $clog2(LOSS_FRAMES + 1);

  lock_st_e      st_q, st_nxt;
  logic [GW-1:0] good_q, good_nxt;
  logic [BW-1:0] bad_q, bad_nxt;

  always_comb begin
    st_nxt   = st_q;
    good_nxt = good_q;
    bad_nxt  = bad_q;
    slip_req = 1'b0;
    if (frame_end) begin
      if (st_q == ST_HUNT) begin
        if (frame_ok) begin
          if (good_q == GW'(LOCK_FRAMES - 1)) begin
            st_nxt   = ST_LOCK;
            good_nxt = '0;
            bad_nxt  = '0;
          end else begin
            good_nxt = good_q + 1'b1;
          end
        end else begin
          good_nxt = '0;
          slip_req = 1'b1;
        end
      end else begin
        if (frame_ok) begin
          bad_nxt = '0;
        end else if (bad_q == BW'(LOSS_FRAMES - 1)) begin
          st_nxt   = ST_HUNT;
          bad_nxt  = '0;
          good_nxt = '0;
          slip_req = 1'b1;
        end else begin
          bad_nxt = bad_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge pwrdn_n) begin
    if (!pwrdn_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      st_q   <= st_nxt;
      good_q <= good_nxt;
      bad_q  <= bad_nxt;
    end
  end

  assign locked     = (st_q == ST_LOCK);
  assign locked_nxt = (st_nxt == ST_LOCK);
endmodule

// File: rtl/emb_deser_wordout.sv
module emb_deser_wordout #(
  parameter int PAY_W = 10
) (
  input  logic             clk,
  input  logic             pwrdn_n,
  input  logic             frame_end,
  input  logic             locked_nxt,
  input  logic             en,
  input  logic             strb_fall,
  input  logic [PAY_W-1:0] payload,
  output logic [PAY_W-1:0] word_q,
  output logic             word_vld,
  output logic             word_strb
);
  localparam int FW   = PAY_W + 2;
  localparam int CW   = $clog2(FW);
  localparam int HALF = FW / 2;

  logic [PAY_W-1:0] data_q;
  logic             vld_q;
  logic [CW-1:0]    ph_q;
  logic             take;

  assign take = frame_end & locked_nxt;

  always_ff @(posedge clk or negedge pwrdn_n) begin
    if (!pwrdn_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      ph_q   <= '0;
    end else begin
      vld_q <= take;
      if (take) begin
        data_q <= payload;
        ph_q   <= '0;
      end else if (ph_q != CW'(FW-1)) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign word_q    = en ? data_q : '0;
  assign word_vld  = vld_q;
  assign word_strb = en & ((ph_q >= CW'(HALF)) ^ strb_fall);
endmodule

// File: rtl/emb_clk_deser.sv
module emb_clk_deser #(
  parameter int PAY_W       = 10,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic             clk,
  input  logic             pwrdn_n,
  input  logic             ser_in,
  input  logic             strb_fall,
  output logic [PAY_W-1:0] word_q,
  output logic             word_vld,
  output logic             word_strb,
  output logic             lock_n,
  output logic             out_en
);
  logic             frame_end, frame_ok, slip_req;
  logic             locked, locked_nxt;
  logic [PAY_W-1:0] payload;

  emb_deser_framer #(.PAY_W(PAY_W)) u_framer (
    .clk       (clk),
    .pwrdn_n   (pwrdn_n),
    .ser_in    (ser_in),
    .slip_req  (slip_req),
    .frame_end (frame_end),
    .frame_ok  (frame_ok),
    .payload   (payload)
  );

  emb_deser_lock #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .LOSS_FRAMES (LOSS_FRAMES)
  ) u_lock (
    .clk        (clk),
    .pwrdn_n    (pwrdn_n),
    .frame_end  (frame_end),
    .frame_ok   (frame_ok),
    .locked     (locked),
    .locked_nxt (locked_nxt),
    .slip_req   (slip_req)
  );

  emb_deser_wordout #(.PAY_W(PAY_W)) u_out (
    .clk        (clk),
    .pwrdn_n    (pwrdn_n),
    .frame_end  (frame_end),
    .locked_nxt (locked_nxt),
    .en         (locked),
    .strb_fall  (strb_fall),
    .payload    (payload),
    .word_q     (word_q),
    .word_vld   (word_vld),
    .word_strb  (word_strb)
  );

  assign lock_n = ~locked;
  assign out_en = locked;
endmodule

// File: rtl/emb_clk_deser_chk.sv
module emb_clk_deser_chk #(
  parameter int PAY_W = 10
) (
  input logic             clk,
  input logic             pwrdn_n,
  input logic             strb_fall,
  input logic [PAY_W-1:0] word_q,
  input logic             word_vld,
  input logic             word_strb,
  input logic             lock_n,
  input logic             out_en
);
  localparam int FW = PAY_W + 2;
  localparam int KW = $clog2(FW + 4);

  logic [KW-1:0] gap_q;
  logic          had_vld_q;

  always_ff @(posedge clk or negedge pwrdn_n) begin
    if (!pwrdn_n) begin
      gap_q     <= '0;
      had_vld_q <= 1'b0;
    end else begin
      if (word_vld) gap_q <= '0;
      else if (gap_q != {KW{1'b1}}) gap_q <= gap_q + 1'b1;
      if (word_vld) had_vld_q <= 1'b1;
      else if (!out_en) had_vld_q <= 1'b0;
    end
  end

  p_vld_needs_lock_r3: assert property (@(posedge clk) disable iff (!pwrdn_n)
    word_vld |-> out_en);

  p_quiet_unlocked_r3: assert property (@(posedge clk) disable iff (!pwrdn_n)
    !out_en |-> (word_q == '0) && !word_strb && !word_vld);

  p_pwrdn_clear_r9: assert property (@(posedge clk)
    !pwrdn_n |-> lock_n && !out_en);

  p_drop_no_word_r6: assert property (@(posedge clk) disable iff (!pwrdn_n)
    $rose(lock_n) |-> !word_vld);

  p_word_spacing_r10: assert property (@(posedge clk) disable iff (!pwrdn_n)
    (word_vld && had_vld_q && $past(out_en)) |-> (gap_q == KW'(FW-1)));

  p_strobe_mid_r8: assert property (@(posedge clk) disable iff (!pwrdn_n)
    (word_strb != $past(word_strb) && out_en && $past(out_en) &&
     $stable(strb_fall) && had_vld_q)
    |-> (gap_q == KW'(FW/2 - 1)) || (gap_q == KW'(FW-1)));
endmodule

bind emb_clk_deser emb_clk_deser_chk #(.PAY_W(PAY_W)) u_chk (
  .clk       (clk),
  .pwrdn_n   (pwrdn_n),
  .strb_fall (strb_fall),
  .word_q    (word_q),
  .word_vld  (word_vld),
  .word_strb (word_strb),
  .lock_n    (lock_n),
  .out_en    (out_en)
);

// File: tb/tb_emb_clk_deser.sv
module tb_emb_clk_deser;
  logic       clk = 1'b0;
  logic       pwrdn_n = 1'b1;
  logic       ser_in = 1'b0;
  logic       strb_fall = 1'b0;
  logic [9:0] word_q;
  logic       word_vld, word_strb, lock_n, out_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [9:0] TRAIN = 10'h01F;

  always #4 clk = ~clk;

  emb_clk_deser dut (
    .clk(clk), .pwrdn_n(pwrdn_n), .ser_in(ser_in), .strb_fall(strb_fall),
    .word_q(word_q), .word_vld(word_vld), .word_strb(word_strb),
    .lock_n(lock_n), .out_en(out_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] frame_bits(input logic [9:0] pay,
                                             input logic st, input logic sp);
    return {sp, pay, st};  // bit 0 is sent first
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic send_bit(input logic b);
    ser_in = b;
    @(negedge clk);
  endtask

  task automatic send_range(input logic [11:0] f, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_bit(f[i]);
  endtask

  task automatic send_frame(input logic [9:0] pay, input logic st, input logic sp);
    send_range(frame_bits(pay, st, sp), 0, 11);
  endtask

  task automatic do_reset();
    @(negedge clk);
    pwrdn_n = 1'b0;
    #1;
    chk(lock_n == 1'b1, "R9 lock_n in powerdown", lock_n, 1);
    chk(out_en == 1'b0, "R9 out_en in powerdown", out_en, 0);
    chk(word_vld == 1'b0 && word_q == 10'h0, "R3 outputs idle in powerdown", word_q, 0);
    repeat (2) @(negedge clk);
    pwrdn_n = 1'b1;
  endtask

  task automatic lock_with_training();
    for (int i = 0; i < 8; i++) send_frame(TRAIN, 1'b1, 1'b0);
  endtask

  task automatic t_lock_data();
    logic [9:0] p;
    do_reset();
    for (int i = 0; i < 7; i++) begin
      p = 10'((i * 37 + 5) ^ (i << 6));
      send_frame(p, 1'b1, 1'b0);
      chk(lock_n == 1'b1, "R2 no lock before eighth word", lock_n, 1);
      chk(word_vld == 1'b0 && word_q == 10'h0 && out_en == 1'b0,
          "R3 quiet while hunting", word_q, 0);
    end
    send_frame(10'h3C6, 1'b1, 1'b0);
    chk(lock_n == 1'b0 && out_en == 1'b1, "R2 lock after eighth word", lock_n, 0);
    chk(word_vld == 1'b1 && word_q == 10'h3C6, "R2 eighth word presented", word_q, 10'h3C6);
    send_frame(10'h2A5, 1'b1, 1'b0);
    chk(word_q == 10'h2A5, "R1 payload LSB first", word_q, 10'h2A5);
    send_frame(10'h001, 1'b1, 1'b0);
    chk(word_q == 10'h001, "R1 bit 0 placement", word_q, 10'h001);
    send_frame(10'h200, 1'b1, 1'b0);
    chk(word_q == 10'h200 && word_vld, "R1 bit 9 placement", word_q, 10'h200);
    send_bit(1'b1);
    chk(word_vld == 1'b0, "R10 valid lasts one cycle", word_vld, 0);
  endtask

  task automatic t_slip();
    do_reset();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_frame(TRAIN, 1'b1, 1'b0);
    chk(lock_n == 1'b1, "R4 still hunting after ten training words", lock_n, 1);
    send_frame(TRAIN, 1'b1, 1'b0);
    chk(lock_n == 1'b0, "R4 lock after eleventh training word", lock_n, 0);
    chk(word_vld && word_q == TRAIN, "R7 training word presented", word_q, TRAIN);
  endtask

  task automatic t_loss();
    for (int i = 0; i < 3; i++) begin
      send_frame(10'h155, 1'b1, 1'b1);
      chk(lock_n == 1'b0, "R5 lock kept under three bad words", lock_n, 0);
      chk(word_vld && word_q == 10'h155, "R5 bad word still presented", word_q, 10'h155);
    end
    send_frame(TRAIN, 1'b1, 1'b0);
    chk(lock_n == 1'b0 && word_q == TRAIN, "R7 training word while locked", word_q, TRAIN);
    for (int i = 0; i < 3; i++) send_frame(10'h0AA, 1'b0, 1'b0);
    chk(lock_n == 1'b0, "R5 good word restarted the bad run", lock_n, 0);
    send_frame(10'h0AA, 1'b0, 1'b0);
    chk(lock_n == 1'b1 && out_en == 1'b0, "R6 lock lost on fourth bad word", lock_n, 1);
    chk(word_vld == 1'b0 && word_q == 10'h0, "R6 fourth bad word not presented", word_vld, 0);
  endtask

  task automatic t_strobe();
    logic [11:0] f;
    f = frame_bits(10'h123, 1'b1, 1'b0);
    do_reset();
    strb_fall = 1'b0;
    lock_with_training();
    chk(word_vld && word_strb == 1'b0, "R8 rising mode low at valid", word_strb, 0);
    send_range(f, 0, 4);
    chk(word_strb == 1'b0, "R8 rising mode low after five bits", word_strb, 0);
    send_range(f, 5, 5);
    chk(word_strb == 1'b1, "R8 rising edge six cycles after valid", word_strb, 1);
    send_range(f, 6, 11);
    chk(word_vld && word_strb == 1'b0 && word_q == 10'h123, "R8 strobe back low at next word", word_strb, 0);
    strb_fall = 1'b1;
    #1;
    chk(word_strb == 1'b1, "R8 falling mode high at valid", word_strb, 1);
    send_range(f, 0, 4);
    chk(word_strb == 1'b1, "R8 falling mode high after five bits", word_strb, 1);
    send_range(f, 5, 5);
    chk(word_strb == 1'b0, "R8 falling edge six cycles after valid", word_strb, 0);
    send_range(f, 6, 11);
    strb_fall = 1'b0;
  endtask

  task automatic t_pwrdn();
    do_reset();
    lock_with_training();
    chk(lock_n == 1'b0, "R9 locked before powerdown", lock_n, 0);
    do_reset();
    for (int i = 0; i < 7; i++) send_frame(TRAIN, 1'b1, 1'b0);
    chk(lock_n == 1'b1, "R9 lock count cleared by powerdown", lock_n, 1);
    send_frame(TRAIN, 1'b1, 1'b0);
    chk(lock_n == 1'b0, "R9 relock after eight words", lock_n, 0);
  endtask

  initial begin
    #1 pwrdn_n = 1'b0;
    t_lock_data();
    t_slip();
    t_loss();
    t_strobe();
    t_pwrdn();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule